// File: doc/BRIEF.md
# Fixed-Priority Register Bus Arbiter with Software Lock

This block decides which of three initiators may drive a shared internal register-access bus: two embedded processors and one host-side interface. Each initiator raises a request line and holds it until the bus reports that its transaction is done. The arbiter answers with a one-hot grant. It hands the bus out only when the bus is idle. The first processor always beats the second, and the second always beats the host.

Either processor can also claim the bus for a run of transactions, for example an atomic read-modify-write. To do so it sets a lock bit in its own flag register. A set lock bit acts as a standing request. Once the locking processor owns the bus, it keeps the grant across any number of completed transactions until it clears the bit. Each processor's flag register reports the lock bit and a grant-status bit, so software can poll until the bus is really its own.

Top module: `regarb_top`

## Requirements
- R1: While reset is asserted, and after reset is released, no grant is given, both lock bits read 0 and both flag read words read 0.
- R2: At most one bit of `gnt_o` is high in any cycle.
- R3: When no grant is held, the arbiter grants at the next clock edge to the highest-priority pending initiator. Index 0 (processor 1) ranks above index 1 (processor 2), which ranks above index 2 (host). A request counts as pending when its `req_i` bit is 1 or, for a processor, when its lock bit is 1.
- R4: A grant that is not locked stays with its owner, whatever other requests arrive, until the owner's transaction ends. It ends when `xfer_done_i` is 1, or when the owner's request falls.
- R5: When a grant is released, `gnt_o` is all-zero for exactly one cycle, and the next winner is granted at the edge after that.
- R6: When `flag_wr_i[p]` is 1, the value on `flag_wbit_i[p]` is stored as processor p's lock bit. It reads back at bit 7 of that processor's 16-bit word in `flag_rdata_o` from the next cycle on.
- R7: While the owning processor's lock bit is 1, the grant stays with it, even across `xfer_done_i` pulses and requests from the other initiators.
- R8: After the owner clears its lock bit, a transaction still in flight (request high) keeps the grant until `xfer_done_i`. With no transaction in flight, the grant is released at the edge after the lock bit reads 0.
- R9: When both lock bits are set on an idle bus, processor 1 receives the grant. Processor 2 keeps waiting and its grant-status bit reads 0.
- R10: Bit 15 of processor p's flag read word equals `gnt_o[p]` in every cycle.
- R11: All flag read bits other than bits 7 and 15 read 0.
- R12: An `xfer_done_i` pulse while no grant is held has no effect on the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 3 | Transaction request per initiator: [0] processor 1, [1] processor 2, [2] host |
| xfer_done_i | input | 1 | The current transaction completes in this cycle |
| flag_wr_i | input | 2 | Write strobe for each processor's lock bit |
| flag_wbit_i | input | 2 | Value written to the lock bit (flag bit 7) |
| flag_rdata_o | output | 32 | Flag read words, 16 bits per processor, processor p in bits [16p+15:16p] |
| gnt_o | output | 3 | One-hot bus grant, same index order as req_i |

## Verification
The case that matters is a transaction end landing in the same cycle as a lock-bit change. A done pulse can arrive while the owner's lock bit is set, or the lock bit can be cleared while the owner's request is still up. Both orderings sit in the vector table. One row pulses done under a live lock and the grant is expected to hold. Another clears the lock with a transaction open, and release is expected only at the later done. A third clears the lock with nothing in flight, and release is expected one edge after the bit reads 0. Each row's grant and flag words are compared after every edge against expected values worked out from the requirements.

// File: rtl/regarb_pkg.sv
package regarb_pkg;

  // Default shape of the arbiter
  localparam int DEF_N_PROC   = 2;   // processors that can lock the bus
  localparam int DEF_FLAG_W   = 16;  // width of a processor flag word
  localparam int DEF_LOCK_POS = 7;   // lock request bit inside the flag word
  localparam int DEF_STAT_POS = 15;  // grant status bit inside the flag word
  localparam int RST_STAGES   = 2;   // reset release synchronizer depth

endpackage

// File: rtl/regarb_rst_sync.sv
module regarb_rst_sync #(
  parameter int STAGES = regarb_pkg::RST_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/regarb_pick.sv
module regarb_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] win_o
);

  // seen[i] is high when some lower index (higher priority) requests
  logic [N-1:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign win_o[i] = req_i[i] & ~seen[i];
    if (i < N-1) begin : g_chain
      assign seen[i+1] = seen[i] | req_i[i];
    end
  end

endmodule

// File: rtl/regarb_flag.sv
module regarb_flag #(
  parameter int FLAG_W   = regarb_pkg::DEF_FLAG_W,
  parameter int LOCK_POS = regarb_pkg::DEF_LOCK_POS,
  parameter int STAT_POS = regarb_pkg::DEF_STAT_POS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              wbit_i,
  input  logic              gnt_i,
  output logic              lock_o,
  output logic [FLAG_W-1:0] rdata_o
);

  logic lock_q;
  logic lock_d;
  logic lock_en;

  // next state
  always_comb begin
    lock_en = wr_i;
    lock_d  = wbit_i;
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (lock_en) begin
      lock_q <= lock_d;
    end
  end

  // read word: lock request and grant status, everything else zero
  always_comb begin
    rdata_o           = '0;
    rdata_o[LOCK_POS] = lock_q;
    rdata_o[STAT_POS] = gnt_i;
  end

  assign lock_o = lock_q;

endmodule

// File: rtl/regarb_grant.sv
module regarb_grant #(
  parameter int N_PROC = regarb_pkg::DEF_N_PROC,
  parameter int N_INIT = N_PROC + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_INIT-1:0] req_i,
  input  logic [N_PROC-1:0] lock_i,
  input  logic              done_i,
  output logic [N_INIT-1:0] gnt_o
);

  logic [N_INIT-1:0] gnt_q;
  logic [N_INIT-1:0] gnt_d;
  logic              gnt_en;
  logic [N_INIT-1:0] eff_req;
  logic [N_INIT-1:0] winner;
  logic              bus_idle;
  logic              owner_locked;
  logic              owner_busy;
  logic              release_now;

  // a set lock bit is a standing request from that processor
  assign eff_req = req_i | N_INIT'(lock_i);

  regarb_pick #(.N(N_INIT)) u_pick (
    .req_i (eff_req),
    .win_o (winner)
  );

  // next state
  always_comb begin
    bus_idle     = (gnt_q == '0);
    owner_locked = |(gnt_q[N_PROC-1:0] & lock_i);
    owner_busy   = |(gnt_q & req_i);
    release_now  = !bus_idle && !owner_locked && (done_i || !owner_busy);
    gnt_en       = bus_idle || release_now;
    if (bus_idle) begin
      gnt_d = winner;
    end else begin
      gnt_d = '0;
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q <= '0;
    end else if (gnt_en) begin
      gnt_q <= gnt_d;
    end
  end

  assign gnt_o = gnt_q;

endmodule

// File: rtl/regarb_top.sv
module regarb_top #(
  parameter int N_PROC   = regarb_pkg::DEF_N_PROC,
  parameter int FLAG_W   = regarb_pkg::DEF_FLAG_W,
  parameter int LOCK_POS = regarb_pkg::DEF_LOCK_POS,
  parameter int STAT_POS = regarb_pkg::DEF_STAT_POS,
  localparam int N_INIT  = N_PROC + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_INIT-1:0]        req_i,
  input  logic                     xfer_done_i,
  input  logic [N_PROC-1:0]        flag_wr_i,
  input  logic [N_PROC-1:0]        flag_wbit_i,
  output logic [N_PROC*FLAG_W-1:0] flag_rdata_o,
  output logic [N_INIT-1:0]        gnt_o
);

  logic              rst_sync_n;
  logic [N_PROC-1:0] lock_q;
  logic [N_INIT-1:0] gnt_w;

  regarb_rst_sync #(.STAGES(regarb_pkg::RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar p = 0; p < N_PROC; p++) begin : g_proc
    regarb_flag #(
      .FLAG_W   (FLAG_W),
      .LOCK_POS (LOCK_POS),
      .STAT_POS (STAT_POS)
    ) u_flag (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_i    (flag_wr_i[p]),
      .wbit_i  (flag_wbit_i[p]),
      .gnt_i   (gnt_w[p]),
      .lock_o  (lock_q[p]),
      .rdata_o (flag_rdata_o[p*FLAG_W +: FLAG_W])
    );
  end

  regarb_grant #(.N_PROC(N_PROC), .N_INIT(N_INIT)) u_grant (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .req_i  (req_i),
    .lock_i (lock_q),
    .done_i (xfer_done_i),
    .gnt_o  (gnt_w)
  );

  assign gnt_o = gnt_w;

endmodule

// File: rtl/regarb_chk.sv
module regarb_chk #(
  parameter int N_PROC = 2,
  parameter int N_INIT = N_PROC + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_INIT-1:0] req_i,
  input logic              done_i,
  input logic [N_PROC-1:0] lock_q,
  input logic [N_INIT-1:0] gnt_o
);

  logic [N_INIT-1:0] eff;
  assign eff = req_i | N_INIT'(lock_q);

  a_r2_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  a_r3_grant_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gnt_o) == '0 && gnt_o != '0) |-> $past(|eff));

  a_r4_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o != '0 && !done_i && (|(gnt_o & req_i))) |=> (gnt_o == $past(gnt_o)));

  a_r5_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gnt_o) != '0 && gnt_o != '0) |-> (gnt_o == $past(gnt_o)));

  a_r7_lock_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gnt_o[N_PROC-1:0] & lock_q)) |=> (gnt_o == $past(gnt_o)));

endmodule

bind regarb_top regarb_chk #(.N_PROC(N_PROC), .N_INIT(N_INIT)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .req_i  (req_i),
  .done_i (xfer_done_i),
  .lock_q (lock_q),
  .gnt_o  (gnt_o)
);

// File: tb/test_regarb_top.sv
module test_regarb_top;

  logic        clk;
  logic        rst_n;
  logic [2:0]  req_i;
  logic        xfer_done_i;
  logic [1:0]  flag_wr_i;
  logic [1:0]  flag_wbit_i;
  logic [31:0] flag_rdata_o;
  logic [2:0]  gnt_o;

  int checks;
  int errors;
  logic [1:0] lock_m;

  regarb_top i_regarb_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .xfer_done_i  (xfer_done_i),
    .flag_wr_i    (flag_wr_i),
    .flag_wbit_i  (flag_wbit_i),
    .flag_rdata_o (flag_rdata_o),
    .gnt_o        (gnt_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // row: req[2:0] _ done _ {wr1,wr0} _ lock0 value _ lock1 value _ expected grant
  localparam logic [10:0] VEC [0:34] = '{
    11'b111_0_00_0_0_001, // R3 processor 1 wins
    11'b111_0_00_0_0_001, // R4 held
    11'b111_1_00_0_0_000, // R5 release on done
    11'b110_0_00_0_0_010, // R3 processor 2 over host
    11'b111_0_00_0_0_010, // R4 no preemption
    11'b111_1_00_0_0_000, // R5
    11'b101_0_00_0_0_001, // R3
    11'b101_1_00_0_0_000,
    11'b100_0_00_0_0_100, // R3 host alone
    11'b100_1_00_0_0_000,
    11'b000_0_00_0_0_000,
    11'b000_0_10_0_1_000, // R6 processor 2 sets lock
    11'b000_0_00_0_0_010, // R6 lock acts as request
    11'b011_0_00_0_0_010, // R7
    11'b011_1_00_0_0_010, // R7 done under lock
    11'b101_0_00_0_0_010, // R7 others wait
    11'b001_0_10_0_0_010, // R8 clear lock
    11'b001_0_00_0_0_000, // R8 release, nothing in flight
    11'b001_0_00_0_0_001,
    11'b001_1_00_0_0_000,
    11'b000_0_11_1_1_000, // R9 both lock
    11'b000_0_00_0_0_001, // R9 processor 1 wins
    11'b000_0_00_0_0_001, // R9 processor 2 status 0
    11'b000_0_01_0_0_001, // R8
    11'b000_0_00_0_0_000,
    11'b000_0_00_0_0_010, // R9 waiting lock served
    11'b000_0_10_0_0_010,
    11'b000_0_00_0_0_000,
    11'b000_0_00_0_0_000,
    11'b000_0_01_1_0_000, // R6
    11'b000_0_00_0_0_001,
    11'b001_0_01_0_0_001, // R8 clear with transaction open
    11'b001_0_00_0_0_001, // R8 still in flight
    11'b001_1_00_0_0_000, // R8 released at done
    11'b000_0_00_0_0_000
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  function automatic logic [31:0] flag_exp(input logic [1:0] lk, input logic [2:0] g);
    logic [31:0] w;
    w = '0;
    for (int p = 0; p < 2; p++) begin
      w[p*16 + 7]  = lk[p];
      w[p*16 + 15] = g[p];
    end
    return w;
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    lock_m = '0;
    rst_n = 1'b0;
    req_i = '0;
    xfer_done_i = 1'b0;
    flag_wr_i = '0;
    flag_wbit_i = '0;
    repeat (3) @(negedge clk);
    check("R1 grant in reset", {29'd0, gnt_o}, 32'd0);
    check("R1 flags in reset", flag_rdata_o, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 grant after reset", {29'd0, gnt_o}, 32'd0);
    check("R1 R11 flags after reset", flag_rdata_o, 32'd0);

    for (int v = 0; v < 35; v++) begin
      req_i       = VEC[v][10:8];
      xfer_done_i = VEC[v][7];
      flag_wr_i   = VEC[v][6:5];
      flag_wbit_i = {VEC[v][3], VEC[v][4]};
      @(negedge clk);
      for (int p = 0; p < 2; p++) begin
        if (flag_wr_i[p]) lock_m[p] = flag_wbit_i[p];
      end
      check($sformatf("R2 R3 R4 R5 R7 R8 R9 grant row %0d", v),
            {29'd0, gnt_o}, {29'd0, VEC[v][2:0]});
      check($sformatf("R6 R10 R11 flags row %0d", v),
            flag_rdata_o, flag_exp(lock_m, VEC[v][2:0]));
    end
    req_i = '0;
    xfer_done_i = 1'b0;
    flag_wr_i = '0;
    flag_wbit_i = '0;

    // R12: done with no owner
    xfer_done_i = 1'b1;
    @(negedge clk);
    check("R12 idle done", {29'd0, gnt_o}, 32'd0);
    xfer_done_i = 1'b0;
    req_i = 3'b100;
    @(negedge clk);
    check("R12 host granted after stray done", {29'd0, gnt_o}, 32'd4);
    xfer_done_i = 1'b1;
    @(negedge clk);
    check("R5 host released", {29'd0, gnt_o}, 32'd0);
    xfer_done_i = 1'b0;
    req_i = '0;

    // R1: reset while a lock is held
    flag_wr_i = 2'b01;
    flag_wbit_i = 2'b01;
    @(negedge clk);
    flag_wr_i = '0;
    flag_wbit_i = '0;
    @(negedge clk);
    check("R6 lock grant before reset", flag_rdata_o, 32'h0000_8080);
    rst_n = 1'b0;
    #1;
    check("R1 grant cleared by reset", {29'd0, gnt_o}, 32'd0);
    check("R1 lock cleared by reset", flag_rdata_o, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 no grant after re-reset", {29'd0, gnt_o}, 32'd0);
    check("R1 lock stays clear", flag_rdata_o, 32'd0);

    summary();
    $finish;
  end

endmodule